// File: doc/BRIEF.md
# External Interrupt Sense and Pending Front End

This block sits between a chip's interrupt inputs and its priority arbiter. It takes a small set of external interrupt pins, which are asynchronous and active low, and a wider set of internal sources, which are synchronous and active low. For each source it produces one "active and enabled" bit that the downstream priority logic consumes. External pins pass through a two-flop synchroniser. Each pin then follows its own programmable sense mode. In level-low mode a pin is active while it is held low. In falling-edge mode a high-to-low transition is caught in a pending latch, and the latch holds until software acknowledges it. Internal sources are always level-low and are never latched.

Software drives the block through a single-cycle register port. A write takes effect at the clock edge where `wr_en` is high. A read is combinational on `reg_sel`. All source-indexed registers number their bits MSB-first: source `b` occupies bit `31-b`. Each external pin keeps its pending latch in a two-state machine. In state `PND_IDLE` nothing is pending. The transition *catch* (`PND_IDLE` to `PND_HELD`) fires on a falling edge while the pin is in edge mode. In state `PND_HELD` an edge is pending. The transition *release* (`PND_HELD` to `PND_IDLE`) fires when an acknowledge arrives in a cycle with no new edge. The transition *drop* (`PND_HELD` to `PND_IDLE`) fires when the pin is switched to level mode.

Top module: `irq_sense_front`

## Requirements
- R1: After reset, every register reads 0: all masks, all forces, all pending bits, and all sense bits, so every pin starts in level mode. Both active vectors are 0. The synchroniser flops reset to the idle-high level, so pins that are held high after reset produce no edge.
- R2: The register select codes are: 0 internal mask, 1 internal force, 2 external mask, 3 external force, 4 external pending (write one to clear), 5 sense configuration. Codes 6 and 7 read 0. In registers 0 to 4, source or pin `b` sits at bit `31-b`. Bits with no source behind them read 0.
- R3: In the sense configuration register, pin 0 uses bit 15 and pin n uses bit 15-n, so pins 1 to 7 occupy bits 14 down to 8. A value of 1 selects falling-edge mode and 0 selects level-low mode.
- R4: A masked-in pin in level mode drives its active bit high two clock edges after the pin goes low. It drops again when the pin returns high, and nothing is latched.
- R5: In edge mode, a synchronised sample of 1 followed by a 0 sets the pin's pending bit on the next edge, which is three edges after the pin falls. The bit then stays set after the pin returns high. A pin that stays low, or that rises, sets nothing.
- R6: Writing 1 to a bit of the pending register clears that bit. Writing 0 leaves it unchanged.
- R7: If an acknowledge and a new falling edge arrive in the same cycle, the pending bit stays set.
- R8: An internal source's active bit follows its active-low input combinationally while its mask bit is 1, and it is never latched.
- R9: A force bit of 1 makes its source active as though its input were asserted, still subject to the mask. Forcing does not set a pending bit.
- R10: A mask bit of 0 holds the source's active bit at 0. An edge on a masked pin still latches as pending, and the source becomes active as soon as its mask bit is set.
- R11: Switching a pin from edge mode to level mode discards its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_n | input | NUM_EXT | Asynchronous external interrupt pins, active low |
| int_src_n | input | NUM_INT | Synchronous internal interrupt sources, active low |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| wr_data | input | 32 | Write data, MSB-first source numbering |
| rd_data | output | 32 | Combinational read data for `reg_sel` |
| int_active | output | NUM_INT | Active and enabled internal sources, bit i = source i |
| ext_active | output | NUM_EXT | Active and enabled external pins, bit n = pin n |

## Verification
On every cycle, the assertions check the pending state machine. A pending bit rises only after a falling edge seen in edge mode. The bit holds until an acknowledge arrives, and it survives an acknowledge that coincides with a new edge. A cleared mask silences its whole active vector. Only the directed scenarios can show the register bit layout and the exact two- and three-edge latencies. They also cover the fact that a held-low or rising pin leaves pending clear, that forcing never latches, and that a mode switch discards pending state.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;
    localparam int REG_W     = 32;
    localparam int SEL_W     = 3;
    localparam int SENSE_TOP = 15;

    typedef enum logic [SEL_W-1:0] {
        SEL_INT_MASK  = 3'd0,
        SEL_INT_FORCE = 3'd1,
        SEL_EXT_MASK  = 3'd2,
        SEL_EXT_FORCE = 3'd3,
        SEL_EXT_PEND  = 3'd4,
        SEL_SENSE     = 3'd5,
        SEL_RSVD6     = 3'd6,
        SEL_RSVD7     = 3'd7
    } reg_sel_e;

    typedef enum logic {
        PND_IDLE = 1'b0,
        PND_HELD = 1'b1
    } pend_state_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] pin_sync
);
    logic [W-1:0] chain_q [STAGES];

    // Flops reset to the idle-high level so no false edge follows reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '1;
        end else begin
            chain_q[0] <= pin_async;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_edge_pend.sv
module irq_edge_pend
    import irq_front_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level_n,
    input  logic edge_mode,
    input  logic ack,
    output logic pending,
    output logic asserted
);
    pend_state_e state_q, state_d;
    logic        prev_q;
    logic        fall;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= level_n;
    end

    assign fall = prev_q & ~level_n;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PND_IDLE;
        else     state_q <= state_d;
    end

    // Transitions: catch, release, drop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PND_IDLE: if (edge_mode && fall) state_d = PND_HELD;
            PND_HELD: begin
                if (!edge_mode)         state_d = PND_IDLE;
                else if (ack && !fall)  state_d = PND_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        pending  = (state_q == PND_HELD);
        asserted = edge_mode ? pending : ~level_n;
    end

    assert_rise_after_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(edge_mode && fall));

    assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (pending && edge_mode && !ack) |=> pending);

    assert_ack_race_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (pending && edge_mode && ack && fall) |=> pending);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_front_pkg::*;
#(
    parameter int NUM_EXT = 8,
    parameter int NUM_INT = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [NUM_EXT-1:0] pend_vec,
    output logic [NUM_INT-1:0] int_mask,
    output logic [NUM_INT-1:0] int_force,
    output logic [NUM_EXT-1:0] ext_mask,
    output logic [NUM_EXT-1:0] ext_force,
    output logic [NUM_EXT-1:0] edge_mode,
    output logic [NUM_EXT-1:0] ack,
    output logic [REG_W-1:0]   rd_data
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            int_mask  <= '0;
            int_force <= '0;
            ext_mask  <= '0;
            ext_force <= '0;
            edge_mode <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_INT_MASK:
                    for (int b = 0; b < NUM_INT; b++) int_mask[b] <= wr_data[REG_W-1-b];
                SEL_INT_FORCE:
                    for (int b = 0; b < NUM_INT; b++) int_force[b] <= wr_data[REG_W-1-b];
                SEL_EXT_MASK:
                    for (int n = 0; n < NUM_EXT; n++) ext_mask[n] <= wr_data[REG_W-1-n];
                SEL_EXT_FORCE:
                    for (int n = 0; n < NUM_EXT; n++) ext_force[n] <= wr_data[REG_W-1-n];
                SEL_SENSE:
                    for (int n = 0; n < NUM_EXT; n++) edge_mode[n] <= wr_data[SENSE_TOP-n];
                default: ;
            endcase
        end
    end

    // Write-one-to-clear strobes for the pending latches
    always_comb begin
        for (int n = 0; n < NUM_EXT; n++)
            ack[n] = wr_en && (sel == SEL_EXT_PEND) && wr_data[REG_W-1-n];
    end

    always_comb begin
        rd_data = '0;
        unique case (sel)
            SEL_INT_MASK:
                for (int b = 0; b < NUM_INT; b++) rd_data[REG_W-1-b] = int_mask[b];
            SEL_INT_FORCE:
                for (int b = 0; b < NUM_INT; b++) rd_data[REG_W-1-b] = int_force[b];
            SEL_EXT_MASK:
                for (int n = 0; n < NUM_EXT; n++) rd_data[REG_W-1-n] = ext_mask[n];
            SEL_EXT_FORCE:
                for (int n = 0; n < NUM_EXT; n++) rd_data[REG_W-1-n] = ext_force[n];
            SEL_EXT_PEND:
                for (int n = 0; n < NUM_EXT; n++) rd_data[REG_W-1-n] = pend_vec[n];
            SEL_SENSE:
                for (int n = 0; n < NUM_EXT; n++) rd_data[SENSE_TOP-n] = edge_mode[n];
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_sense_front.sv
module irq_sense_front
    import irq_front_pkg::*;
#(
    parameter int NUM_EXT     = 8,
    parameter int NUM_INT     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EXT-1:0] ext_pin_n,
    input  logic [NUM_INT-1:0] int_src_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    output logic [NUM_INT-1:0] int_active,
    output logic [NUM_EXT-1:0] ext_active
);
    logic [NUM_EXT-1:0] pin_sync;
    logic [NUM_EXT-1:0] pend_vec;
    logic [NUM_EXT-1:0] pin_asserted;
    logic [NUM_EXT-1:0] edge_mode;
    logic [NUM_EXT-1:0] ack;
    logic [NUM_EXT-1:0] ext_mask;
    logic [NUM_EXT-1:0] ext_force;
    logic [NUM_INT-1:0] int_mask;
    logic [NUM_INT-1:0] int_force;

    irq_pin_sync #(.W(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (ext_pin_n),
        .pin_sync  (pin_sync)
    );

    for (genvar n = 0; n < NUM_EXT; n++) begin : g_pin
        irq_edge_pend u_pend (
            .clk       (clk),
            .rst       (rst),
            .level_n   (pin_sync[n]),
            .edge_mode (edge_mode[n]),
            .ack       (ack[n]),
            .pending   (pend_vec[n]),
            .asserted  (pin_asserted[n])
        );
    end

    irq_regs #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .reg_sel   (reg_sel),
        .wr_data   (wr_data),
        .pend_vec  (pend_vec),
        .int_mask  (int_mask),
        .int_force (int_force),
        .ext_mask  (ext_mask),
        .ext_force (ext_force),
        .edge_mode (edge_mode),
        .ack       (ack),
        .rd_data   (rd_data)
    );

    assign ext_active = (pin_asserted | ext_force) & ext_mask;
    assign int_active = (~int_src_n | int_force) & int_mask;

    assert_ext_mask_silences_R10: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && reg_sel == SEL_EXT_MASK && wr_data == '0) |-> ext_active == '0);

    assert_int_mask_silences_R10: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && reg_sel == SEL_INT_MASK && wr_data == '0) |-> int_active == '0);
endmodule

// File: tb/sim_irq_sense_front.sv
`timescale 1ns/1ps
module sim_irq_sense_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ext_pin_n = 8'hFF;
    logic [31:0] int_src_n = 32'hFFFF_FFFF;
    logic        wr_en = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;
    logic [31:0] int_active;
    logic [7:0]  ext_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    irq_sense_front u0 (
        .clk(clk), .rst(rst), .ext_pin_n(ext_pin_n), .int_src_n(int_src_n),
        .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
        .int_active(int_active), .ext_active(ext_active)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] data);
        reg_sel = sel; wr_data = data; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'h0;
    endtask

    task automatic rd(logic [2:0] sel, output logic [31:0] val);
        reg_sel = sel;
        #1;
        val = rd_data;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int s = 0; s < 8; s++) begin
            rd(3'(s), v);
            chk($sformatf("R1 reg %0d after reset", s), v, 32'h0);
        end
        chk("R1 int_active after reset", int_active, 32'h0);
        chk("R1 ext_active after reset", {24'h0, ext_active}, 32'h0);
    endtask

    task automatic t_layout;
        logic [31:0] v;
        wr(3'd0, 32'h8000_0001);
        rd(3'd0, v); chk("R2 int mask readback", v, 32'h8000_0001);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R2 ext mask unimplemented bits", v, 32'hFF00_0000);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, v); chk("R3 sense bits 15..8", v, 32'h0000_FF00);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, v); chk("R2 code 6 reads 0", v, 32'h0);
        wr(3'd0, 32'h0); wr(3'd2, 32'h0); wr(3'd5, 32'h0);
    endtask

    task automatic t_level;
        logic [31:0] v;
        wr(3'd2, 32'h1000_0000);   // pin 3 at bit 28
        ext_pin_n[3] = 1'b0;
        @(posedge clk); #1;
        chk("R4 level latency edge 1", {31'h0, ext_active[3]}, 32'h0);
        @(posedge clk); #1;
        chk("R4 level active at edge 2", {24'h0, ext_active}, 32'h08);
        @(negedge clk); ext_pin_n[3] = 1'b1;
        idle(3);
        chk("R4 level drops, no latch", {24'h0, ext_active}, 32'h0);
        rd(3'd4, v); chk("R4 level sets no pending", v, 32'h0);
    endtask

    task automatic t_edge;
        logic [31:0] v;
        wr(3'd5, 32'h0000_8400);   // pin 0 (bit 15), pin 5 (bit 10)
        wr(3'd2, 32'hFF00_0000);
        ext_pin_n[5] = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R5 not yet pending at edge 2", {31'h0, ext_active[5]}, 32'h0);
        @(posedge clk); #1;
        chk("R5 pending at edge 3", {31'h0, ext_active[5]}, 32'h1);
        @(negedge clk); ext_pin_n[5] = 1'b1;
        idle(3);
        chk("R5 pending held after rise", {24'h0, ext_active}, 32'h20);
        rd(3'd4, v); chk("R5 pending bit 26", v, 32'h0400_0000);
    endtask

    task automatic t_ack;
        logic [31:0] v;
        wr(3'd4, 32'h0);
        rd(3'd4, v); chk("R6 zero write keeps pending", v, 32'h0400_0000);
        wr(3'd4, 32'hFBFF_FFFF);
        rd(3'd4, v); chk("R6 other bits keep pending", v, 32'h0400_0000);
        wr(3'd4, 32'h0400_0000);
        rd(3'd4, v); chk("R6 one clears pending", v, 32'h0);
        chk("R6 active drops after ack", {24'h0, ext_active}, 32'h0);
        ext_pin_n[5] = 1'b0;
        idle(5);
        wr(3'd4, 32'h0400_0000);
        idle(4);
        rd(3'd4, v); chk("R5 steady low does not re-latch", v, 32'h0);
        ext_pin_n[5] = 1'b1;
        idle(5);
        rd(3'd4, v); chk("R5 rising edge sets nothing", v, 32'h0);
    endtask

    task automatic t_race;
        logic [31:0] v;
        ext_pin_n[0] = 1'b0; idle(5);
        ext_pin_n[0] = 1'b1; idle(5);
        rd(3'd4, v); chk("R5 pin 0 pending bit 31", v, 32'h8000_0000);
        @(negedge clk); ext_pin_n[0] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(3'd4, 32'h8000_0000);   // ack lands on the latching edge
        rd(3'd4, v); chk("R7 ack with new edge keeps pending", v, 32'h8000_0000);
        ext_pin_n[0] = 1'b1; idle(4);
        wr(3'd4, 32'h8000_0000);
        rd(3'd4, v); chk("R6 later ack clears", v, 32'h0);
    endtask

    task automatic t_internal;
        wr(3'd0, 32'hC000_0000);   // sources 0 and 1
        int_src_n[1] = 1'b0; #1;
        chk("R8 internal level active", int_active, 32'h2);
        int_src_n[1] = 1'b1; #1;
        chk("R8 internal not latched", int_active, 32'h0);
        int_src_n[5] = 1'b0; #1;
        chk("R10 masked internal source", int_active, 32'h0);
        int_src_n[5] = 1'b1;
    endtask

    task automatic t_force;
        logic [31:0] v;
        wr(3'd1, 32'h0800_0000);   // source 4 at bit 27
        #1; chk("R9 force masked off", int_active, 32'h0);
        wr(3'd0, 32'hC800_0000);
        #1; chk("R9 forced internal active", int_active, 32'h10);
        wr(3'd1, 32'h0);
        #1; chk("R9 unforced internal idle", int_active, 32'h0);
        wr(3'd5, 32'h0000_2000);   // pin 2 edge mode (bit 13)
        wr(3'd3, 32'h2000_0000);   // force pin 2 (bit 29)
        #1; chk("R9 forced pin active", {24'h0, ext_active}, 32'h04);
        idle(4);
        rd(3'd4, v); chk("R9 force sets no pending", v, 32'h0);
        wr(3'd3, 32'h0);
        #1; chk("R9 force removed", {24'h0, ext_active}, 32'h0);
    endtask

    task automatic t_mask_mode;
        logic [31:0] v;
        wr(3'd2, 32'h0);
        wr(3'd5, 32'h0000_0200);   // pin 6 edge mode (bit 9)
        ext_pin_n[6] = 1'b0; idle(5);
        ext_pin_n[6] = 1'b1; idle(5);
        rd(3'd4, v); chk("R10 masked edge still latches", v, 32'h0200_0000);
        chk("R10 masked pin inactive", {24'h0, ext_active}, 32'h0);
        wr(3'd2, 32'h0200_0000);
        #1; chk("R10 unmask exposes pending", {24'h0, ext_active}, 32'h40);
        wr(3'd5, 32'h0);
        idle(1);
        rd(3'd4, v); chk("R11 level switch drops pending", v, 32'h0);
        chk("R11 pin 6 inactive in level mode", {24'h0, ext_active}, 32'h0);
    endtask

    initial begin
        idle(4);
        @(negedge clk); rst = 1'b0;
        idle(2);
        t_reset();
        t_layout();
        t_level();
        t_edge();
        t_ack();
        t_race();
        t_internal();
        t_force();
        t_mask_mode();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule